// File: doc/BRIEF.md
# Programmable Interrupt Priority Controller

This block gathers interrupt requests from a processor's peripherals (host port, two synchronous serial ports, an asynchronous serial port and a timer), from a host command line, from a set of active-low external request pins and from a non-maskable request pin. Software gives each peripheral and each external pin a 2-bit field. That field either disables the source or assigns it one of three maskable levels. The non-maskable request sits alone at the top level.

Every cycle the controller compares the enabled requests with the mask level that the core currently holds. It then presents the winning request as three outputs: a valid strobe, a vector address and the accepted level. The vector table gives each source two instruction words, so the address steps by two per source. Each external pin can be set either to follow its level or to latch falling edges. A latched edge stays pending until the core acknowledges that source's vector. After the acknowledge, the core raises its mask to the accepted level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both configuration registers read as zero, every source is disabled, every pin is in level mode and `irq_valid` is 0.
- R2: A 2-bit level code of 00 disables its source. Codes 01, 10 and 11 enable the source at levels 0, 1 and 2, and `irq_level` reports that level.
- R3: Configuration register 0 (`bus_sel`=0) holds the peripheral codes from bit 0 upward: host port [1:0], serial port 0 [3:2], serial port 1 [5:4], asynchronous serial port [7:6], timer [9:8]. Bits above 9 read as zero whatever was written.
- R4: Configuration register 1 (`bus_sel`=1) holds three bits per external pin k. Bits [3k+1:3k] are the level code and bit 3k+2 is the trigger mode (0 = level, 1 = falling edge). Bits above the last pin read as zero.
- R5: A maskable request is accepted only when its level is strictly greater than `core_mask`. Level 3 is accepted at any mask.
- R6: A falling edge on `nmi_n` is latched as a level-3 request. It wins over every other request and stays pending until its vector is acknowledged.
- R7: The highest accepted level wins. Among equal levels, the lower source index wins. The index order is: non-maskable 0, host command 1, external pins 2 to 2+NUM_EXT-1, then host port, serial port 0, serial port 1, asynchronous serial port, timer.
- R8: In level mode a pin requests only while it is held low. Nothing is latched, so releasing the pin withdraws the request.
- R9: In edge mode a falling edge sets a pending flag that survives the pin's release. An acknowledge clears only the flag of the source whose vector is being presented.
- R10: `irq_vector` equals VEC_BASE + 2*(index+1), where index follows the order of R7. The table holds 128 two-word entries.
- R11: The host command request is always enabled at level 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for the selected configuration register |
| bus_sel | input | 1 | Register select: 0 peripheral codes, 1 external pin setup |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge sensitive |
| host_cmd | input | 1 | Host command request, level held |
| ext_n | input | NUM_EXT | Active-low external request pins |
| periph_req | input | NUM_PER | Peripheral requests, held until serviced |
| core_mask | input | 2 | Current mask level of the core |
| irq_ack | input | 1 | Core acknowledges the presented vector |
| irq_valid | output | 1 | A request is accepted |
| irq_vector | output | ADDR_W | Vector address of the winner |
| irq_level | output | 2 | Level of the winner |

## Verification
The bench builds the block with NUM_EXT=3 and VEC_BASE=0x400. The non-zero base makes every vector check test the base addition as well as the index doubling. Three pins are enough to hold one level-mode pin and two edge-mode pins at different levels at the same time. They also push the reserved region of register 1 down to bit 9, where a stuck reserved bit becomes visible. With these values the bench can test tie breaks between the host command, a pin and a peripheral, and it can show that an edge flag survives an acknowledge aimed at another vector.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int CODE_W = 2;
    localparam int TABLE_ENTRIES = 128;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_TOP = 2'd3;
    localparam lvl_t LVL_HOST_CMD = 2'd2;

    // a non-zero code enables the source
    function automatic logic code_en(input logic [CODE_W-1:0] code);
        return code != '0;
    endfunction

    // codes 1..3 map onto levels 0..2
    function automatic lvl_t code_lvl(input logic [CODE_W-1:0] code);
        return lvl_t'(code - 2'd1);
    endfunction
endpackage

// File: rtl/ipc_regs.sv
module ipc_regs #(
    parameter int DATA_W  = 24,
    parameter int NUM_PER = 5,
    parameter int NUM_EXT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2*NUM_PER-1:0] per_cfg,
    output logic [3*NUM_EXT-1:0] ext_cfg
);
    localparam int PER_BITS = 2 * NUM_PER;
    localparam int EXT_BITS = 3 * NUM_EXT;

    typedef struct packed {
        logic [PER_BITS-1:0] per;
        logic [EXT_BITS-1:0] ext;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (!bus_sel) begin
                st_d.per = bus_wdata[PER_BITS-1:0];
            end else begin
                st_d.ext = bus_wdata[EXT_BITS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // reserved bits come back as zero
    assign bus_rdata = bus_sel ? DATA_W'(st_q.ext) : DATA_W'(st_q.per);
    assign per_cfg   = st_q.per;
    assign ext_cfg   = st_q.ext;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    AST_PER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel) |=> (st_q.per == $past(bus_wdata[PER_BITS-1:0]))); // R3
    AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel) |=> $stable(st_q.ext)); // R4
endmodule

// File: rtl/ipc_pin_cond.sv
module ipc_pin_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic prev;
        logic pend;
    } pin_t;

    pin_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_n;
        if (!edge_mode) begin
            st_d.pend = 1'b0;
        end else begin
            if (clr) begin
                st_d.pend = 1'b0;
            end
            // a fresh edge wins over a clear in the same cycle
            if (st_q.prev && !pin_n) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req = edge_mode ? st_q.pend : !pin_n;

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |=> !st_q.pend); // R8
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && st_q.pend && !clr) |=> st_q.pend); // R9
    AST_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && st_q.prev && !pin_n) |=> st_q.pend); // R9
endmodule

// File: rtl/ipc_arb.sv
module ipc_arb
    import ipc_pkg::*;
#(
    parameter int N     = 11,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]       req,
    input  logic [N-1:0][1:0]  lvl,
    input  lvl_t               mask,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_t               win_lvl
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        // ascending scan: only a strictly higher level displaces the winner
        for (int i = 0; i < N; i++) begin
            if (req[i] && (lvl[i] == LVL_TOP || lvl[i] > mask)) begin
                if (!win_valid || lvl[i] > win_lvl) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(i);
                    win_lvl   = lvl[i];
                end
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int              DATA_W   = 24,
    parameter int              ADDR_W   = 24,
    parameter int              NUM_EXT  = 4,
    parameter int              NUM_PER  = 5,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_sel,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               nmi_n,
    input  logic               host_cmd,
    input  logic [NUM_EXT-1:0] ext_n,
    input  logic [NUM_PER-1:0] periph_req,
    input  logic [1:0]         core_mask,
    input  logic               irq_ack,
    output logic               irq_valid,
    output logic [ADDR_W-1:0]  irq_vector,
    output logic [1:0]         irq_level
);
    localparam int SRC_NMI  = 0;
    localparam int SRC_HCMD = 1;
    localparam int SRC_EXT0 = 2;
    localparam int SRC_PER0 = SRC_EXT0 + NUM_EXT;
    localparam int NUM_SRC  = SRC_PER0 + NUM_PER;
    localparam int IDX_W    = $clog2(NUM_SRC);

    logic [2*NUM_PER-1:0]     per_cfg;
    logic [3*NUM_EXT-1:0]     ext_cfg;
    logic [NUM_SRC-1:0]       src_req;
    logic [NUM_SRC-1:0][1:0]  src_lvl;
    logic [NUM_SRC-1:0]       ack_vec;
    logic                     nmi_req;
    logic [NUM_EXT-1:0]       ext_req;
    logic                     win_valid;
    logic [IDX_W-1:0]         win_idx;
    lvl_t                     win_lvl;

    ipc_regs #(.DATA_W(DATA_W), .NUM_PER(NUM_PER), .NUM_EXT(NUM_EXT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .per_cfg   (per_cfg),
        .ext_cfg   (ext_cfg)
    );

    // non-maskable pin: always edge sensitive
    ipc_pin_cond u_nmi (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (nmi_n),
        .edge_mode (1'b1),
        .clr       (ack_vec[SRC_NMI]),
        .req       (nmi_req)
    );

    assign src_req[SRC_NMI]  = nmi_req;
    assign src_lvl[SRC_NMI]  = LVL_TOP;
    assign src_req[SRC_HCMD] = host_cmd;
    assign src_lvl[SRC_HCMD] = LVL_HOST_CMD;

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        logic [CODE_W-1:0] code;
        assign code = ext_cfg[3*k +: 2];

        ipc_pin_cond u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n[k]),
            .edge_mode (ext_cfg[3*k+2]),
            .clr       (ack_vec[SRC_EXT0+k]),
            .req       (ext_req[k])
        );

        assign src_req[SRC_EXT0+k] = ext_req[k] && code_en(code);
        assign src_lvl[SRC_EXT0+k] = code_lvl(code);
    end

    for (genvar p = 0; p < NUM_PER; p++) begin : g_per
        logic [CODE_W-1:0] code;
        assign code = per_cfg[2*p +: 2];
        assign src_req[SRC_PER0+p] = periph_req[p] && code_en(code);
        assign src_lvl[SRC_PER0+p] = code_lvl(code);
    end

    ipc_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req       (src_req),
        .lvl       (src_lvl),
        .mask      (core_mask),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    always_comb begin
        ack_vec = '0;
        if (irq_ack && win_valid) begin
            ack_vec[win_idx] = 1'b1;
        end
    end

    // slot 0 of the table is left to reset, sources start at slot 1
    assign irq_valid  = win_valid;
    assign irq_level  = win_lvl;
    assign irq_vector = VEC_BASE + ADDR_W'({win_idx, 1'b0}) + ADDR_W'(2);

    AST_MASK_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_level == LVL_TOP || irq_level > core_mask)); // R5
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (irq_valid && irq_level == LVL_TOP)); // R6
    AST_VEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((irq_vector - VEC_BASE) != '0 && (irq_vector[0] == VEC_BASE[0]))); // R10
    AST_HCMD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd && core_mask < 2'd2) |-> (irq_valid && irq_level >= LVL_HOST_CMD)); // R11
    AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_vec)); // R9
    initial begin
        AST_TABLE_FITS: assert (NUM_SRC < TABLE_ENTRIES); // R10
    end
endmodule

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;
    localparam int NE = 3;
    localparam int NP = 5;
    localparam logic [23:0] BASE = 24'h000400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_sel = 1'b0;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic nmi_n = 1'b1, host_cmd = 1'b0, irq_ack = 1'b0;
    logic [NE-1:0] ext_n = '1;
    logic [NP-1:0] periph_req = '0;
    logic [1:0] core_mask = 2'd0;
    logic irq_valid;
    logic [23:0] irq_vector;
    logic [1:0] irq_level;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl #(.DATA_W(24), .ADDR_W(24), .NUM_EXT(NE), .NUM_PER(NP), .VEC_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nmi_n(nmi_n),
        .host_cmd(host_cmd), .ext_n(ext_n), .periph_req(periph_req),
        .core_mask(core_mask), .irq_ack(irq_ack), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_level(irq_level)
    );

    typedef struct {
        bit          is_rd;
        logic        v;
        logic [23:0] vec;
        logic [1:0]  lvl;
        logic [23:0] rd;
        string       tag;
    } item_t;

    item_t sb[$];

    // vector of source index i, from R10
    function automatic logic [23:0] vec_of(input int i);
        return BASE + 24'(2 * (i + 1));
    endfunction

    // monitor: compares at the falling edge, before the driver moves
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_rd) begin
                if (bus_rdata !== it.rd) begin
                    errors++;
                    $display("FAIL %s: rdata=%h expected %h", it.tag, bus_rdata, it.rd);
                end
            end else if (irq_valid !== it.v ||
                         (it.v && (irq_vector !== it.vec || irq_level !== it.lvl))) begin
                errors++;
                $display("FAIL %s: valid=%b vec=%h lvl=%0d expected valid=%b vec=%h lvl=%0d",
                         it.tag, irq_valid, irq_vector, irq_level, it.v, it.vec, it.lvl);
            end
        end
    end

    task automatic adv();
        @(negedge clk);
        #1;
    endtask

    task automatic exp_irq(input logic v, input logic [23:0] vec, input logic [1:0] l,
                           input string tag);
        item_t it;
        it = '{is_rd: 1'b0, v: v, vec: vec, lvl: l, rd: '0, tag: tag};
        sb.push_back(it);
        adv();
    endtask

    task automatic exp_rd(input logic sel, input logic [23:0] d, input string tag);
        item_t it;
        bus_sel = sel;
        it = '{is_rd: 1'b1, v: 1'b0, vec: '0, lvl: '0, rd: d, tag: tag};
        sb.push_back(it);
        adv();
    endtask

    task automatic wr(input logic sel, input logic [23:0] d);
        bus_wr = 1'b1;
        bus_sel = sel;
        bus_wdata = d;
        adv();
        bus_wr = 1'b0;
    endtask

    initial begin
        repeat (3) adv();
        rst_n = 1'b1;
        adv();
        // R1 reset state
        exp_irq(1'b0, '0, '0, "R1 no request after reset");
        exp_rd(1'b0, 24'h0, "R1 peripheral register reset");
        exp_rd(1'b1, 24'h0, "R1 pin register reset");
        // R2 disabled sources
        periph_req = '1;
        exp_irq(1'b0, '0, '0, "R2 code 00 disables");
        periph_req = '0;
        // R3 layout and reserved bits
        wr(1'b0, 24'hFFFFFF);
        exp_rd(1'b0, 24'h0003FF, "R3 reserved bits read zero");
        wr(1'b0, 24'h0001B9);
        exp_rd(1'b0, 24'h0001B9, "R3 peripheral readback");
        // R5 level 0 never above mask 0
        periph_req = 5'b00001;
        exp_irq(1'b0, '0, '0, "R5 level 0 at mask 0 rejected");
        periph_req = 5'b00010;
        exp_irq(1'b1, vec_of(6), 2'd1, "R2 serial port 0 at level 1");
        core_mask = 2'd1;
        exp_irq(1'b0, '0, '0, "R5 level 1 at mask 1 rejected");
        core_mask = 2'd0;
        periph_req = 5'b01010;
        exp_irq(1'b1, vec_of(6), 2'd1, "R7 equal level lower index wins");
        periph_req = 5'b01110;
        exp_irq(1'b1, vec_of(7), 2'd2, "R7 higher level wins");
        core_mask = 2'd2;
        exp_irq(1'b0, '0, '0, "R5 level 2 at mask 2 rejected");
        periph_req = '0;
        host_cmd = 1'b1;
        core_mask = 2'd1;
        exp_irq(1'b1, vec_of(1), 2'd2, "R11 host command at level 2");
        core_mask = 2'd2;
        exp_irq(1'b0, '0, '0, "R11 host command masked at 2");
        host_cmd = 1'b0;
        core_mask = 2'd0;
        // R4 pin setup: pin0 level lvl2, pin1 edge lvl1, pin2 edge lvl0
        wr(1'b1, 24'hFFFFFF);
        exp_rd(1'b1, 24'h0001FF, "R4 reserved bits read zero");
        wr(1'b1, 24'h000173);
        exp_rd(1'b1, 24'h000173, "R4 pin register readback");
        // R8 level mode
        ext_n[0] = 1'b0;
        exp_irq(1'b1, vec_of(2), 2'd2, "R8 level pin held low");
        ext_n[0] = 1'b1;
        exp_irq(1'b0, '0, '0, "R8 release withdraws request");
        // R9 edge mode
        ext_n[1] = 1'b0;
        exp_irq(1'b1, vec_of(3), 2'd1, "R9 edge latched");
        ext_n[1] = 1'b1;
        exp_irq(1'b1, vec_of(3), 2'd1, "R9 held after pin release");
        irq_ack = 1'b1;
        exp_irq(1'b0, '0, '0, "R9 acknowledge clears flag");
        irq_ack = 1'b0;
        periph_req = 5'b00100;
        ext_n[1] = 1'b0;
        exp_irq(1'b1, vec_of(7), 2'd2, "R7 level 2 over pending level 1");
        irq_ack = 1'b1;
        exp_irq(1'b1, vec_of(7), 2'd2, "R9 acknowledge of other vector");
        irq_ack = 1'b0;
        periph_req = '0;
        exp_irq(1'b1, vec_of(3), 2'd1, "R9 flag survives foreign acknowledge");
        irq_ack = 1'b1;
        ext_n[1] = 1'b1;
        exp_irq(1'b0, '0, '0, "R9 own acknowledge clears");
        irq_ack = 1'b0;
        // R6 non-maskable
        core_mask = 2'd3;
        periph_req = 5'b00100;
        nmi_n = 1'b0;
        exp_irq(1'b1, vec_of(0), 2'd3, "R6 non-maskable wins at mask 3");
        nmi_n = 1'b1;
        exp_irq(1'b1, vec_of(0), 2'd3, "R6 non-maskable stays latched");
        irq_ack = 1'b1;
        exp_irq(1'b0, '0, '0, "R6 acknowledge clears, mask 3 blocks rest");
        irq_ack = 1'b0;
        core_mask = 2'd0;
        exp_irq(1'b1, vec_of(7), 2'd2, "R10 serial port 1 vector");
        // R7 ties at level 2 across groups
        ext_n[0] = 1'b0;
        host_cmd = 1'b1;
        exp_irq(1'b1, vec_of(1), 2'd2, "R7 host command lowest index");
        host_cmd = 1'b0;
        exp_irq(1'b1, vec_of(2), 2'd2, "R7 pin before peripheral");
        ext_n[0] = 1'b1;
        periph_req = '0;
        exp_irq(1'b0, '0, '0, "R8 all released");
        adv();
        adv();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule